// File: doc/BRIEF.md
# MDIO Management Master Controller

This block lets software manage Ethernet PHYs over a two-wire management link. It generates the management clock (MDC) from the reference clock and shifts Clause 22 frames out on the bidirectional data line (MDIO). On reads it releases the line and captures the PHY's reply. Software uses a small word-addressed register bank. One register selects the clock ratio and holds a soft reset. Another holds the PHY and register numbers. A read is launched through a command bit. A write is launched simply by storing a data word into the control register.

The MDC rate comes from a 3-bit index into a fixed, non-linear ratio table. Each MDC level lasts half the selected ratio in reference clocks. A busy register covers a transaction from its launch to its final falling MDC edge. Launch requests that arrive during a transaction are dropped, so the frame in flight always completes.

Top module: `mdio_master_ctl`

## Requirements
- R1: The divider index in CFG bits [2:0] selects a reference-clock ratio from {4,4,6,8,10,14,20,28} for indices 0..7. Every MDC high and low level lasts exactly ratio/2 reference clocks.
- R2: MDC is low whenever no transaction is running, including right after reset.
- R3: A write frame carries 32 ones, then 01, then opcode 01, then the 5-bit PHY, then the 5-bit register, then turnaround 10, then 16 data bits. All bits go out MSB first, and the output enable stays high for all 64 bits.
- R4: A read frame uses opcode 10. The output enable is low from the turnaround through the last data bit. When the read ends, STATUS (offset 4) bits [15:0] return the 16 bits taken from MDIO.
- R5: A read starts only when a 1 is written to CMD (offset 1) bit 0. Writing 0 to CMD starts nothing.
- R6: A write to CTRL (offset 3) starts a write frame carrying bits [15:0] of the written word, to the address currently held in ADDR.
- R7: BUSY (offset 5) reads 1 from the cycle after a launch until the frame ends, and reads 0 otherwise. It also reads 0 after reset.
- R8: A CTRL or CMD write that arrives while busy is ignored. The running frame is unchanged, no extra frame follows, and CTRL keeps its old value.
- R9: CFG bit 31 is the soft reset. While it is set, a running frame is abandoned, BUSY reads 0, MDC stays low, and launches are ignored.
- R10: ADDR (offset 2) holds the register number in bits [7:0] and the PHY number in bits [15:8]. Only the low 5 bits of each field are sent.
- R11: MDIO and its enable change only at falling MDC edges and stay constant while MDC is high. Read data is sampled at the end of the low phase, just before MDC rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench measures every MDC level against the ratio table for several divider indices. A generator built on an off-by-one counter would show up as a short or long level. It stores data into CTRL and writes CMD while a frame runs; a design that relaunched would send a second frame or corrupt the first, and the scoreboard would see an unexpected or mismatched frame. It asserts the soft reset mid-frame and then tries to launch, which catches an engine that keeps clocking or restarts. It also writes oversized PHY and register fields and checks the turnaround release on reads, so a wrong truncation or a late release of the line shows up in the captured bits and output-enable pattern.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int PRE_LEN   = 32;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;

  typedef enum logic [1:0] {
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10
  } mdio_opc_e;

  // half of the selected reference-clock ratio
  function automatic logic [4:0] mdc_half(input logic [2:0] sel);
    logic [5:0] ratio;
    case (sel)
      3'd0, 3'd1: ratio = 6'd4;
      3'd2:       ratio = 6'd6;
      3'd3:       ratio = 6'd8;
      3'd4:       ratio = 6'd10;
      3'd5:       ratio = 6'd14;
      3'd6:       ratio = 6'd20;
      default:    ratio = 6'd28;
    endcase
    return ratio[5:1];
  endfunction

  function automatic logic [FRAME_LEN-1:0] pack_frame(input mdio_opc_e opc,
                                                      input logic [4:0] phy,
                                                      input logic [4:0] regn,
                                                      input logic [15:0] data);
    logic [1:0] ta;
    ta = (opc == OPC_READ) ? 2'b11 : 2'b10;
    return {{PRE_LEN{1'b1}}, 2'b01, opc, phy, regn, ta, data};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              mdc,
  output logic              rise_tick,
  output logic              fall_tick
);
  logic [HALF_W-1:0] cnt;
  logic              edge_now;

  assign edge_now  = run && (cnt == half - 1'b1);
  assign rise_tick = edge_now && !mdc;
  assign fall_tick = edge_now && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (edge_now) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // level-length observer, independent of cnt
  logic            prev_mdc;
  logic [HALF_W:0] hold;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_mdc <= 1'b0;
      hold     <= '0;
    end else begin
      prev_mdc <= mdc;
      if (!run)                 hold <= '0;
      else if (mdc != prev_mdc) hold <= 1;
      else                      hold <= hold + 1'b1;
    end
  end

  AST_MDC_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (mdc != prev_mdc)) |-> (hold == {1'b0, half})) else $error("half period"); // R1
  AST_MDC_STOPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc) else $error("mdc not low"); // R2
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int HALF_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              start_rd,
  input  logic              start_wr,
  input  logic [4:0]        phy,
  input  logic [4:0]        regn,
  input  logic [15:0]       wdata,
  input  logic [HALF_W-1:0] half_in,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic [HALF_W-1:0] half_q,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [15:0]       rd_data,
  output logic              done
);
  localparam int IDX_W = $clog2(FRAME_LEN);

  logic [FRAME_LEN-1:0] shreg;
  logic [IDX_W-1:0]     bit_idx;
  logic                 is_rd;
  logic [15:0]          cap;
  logic                 launch;
  logic                 released;

  assign launch   = (start_rd || start_wr) && !busy && !soft_rst;
  assign done     = busy && fall_tick && (bit_idx == IDX_W'(FRAME_LEN - 1));
  assign released = is_rd && (bit_idx >= IDX_W'(TA_POS));
  assign mdio_o   = busy ? shreg[FRAME_LEN-1] : 1'b0;
  assign mdio_oe  = busy && !released;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      is_rd   <= 1'b0;
      shreg   <= '0;
      bit_idx <= '0;
      cap     <= '0;
      rd_data <= '0;
      half_q  <= '0;
    end else if (soft_rst) begin
      busy    <= 1'b0;
      is_rd   <= 1'b0;
      bit_idx <= '0;
    end else if (launch) begin
      busy    <= 1'b1;
      is_rd   <= start_rd;
      shreg   <= pack_frame(start_rd ? OPC_READ : OPC_WRITE, phy, regn, wdata);
      bit_idx <= '0;
      cap     <= '0;
      half_q  <= half_in;
    end else if (busy) begin
      if (rise_tick && is_rd && (bit_idx >= IDX_W'(DATA_POS)))
        cap <= {cap[14:0], mdio_i};
      if (done) begin
        busy <= 1'b0;
        if (is_rd) rd_data <= cap;
      end else if (fall_tick) begin
        shreg   <= shreg << 1;
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !soft_rst && (start_rd || start_wr) && !fall_tick) |=> ($stable(shreg) && $stable(is_rd)))
    else $error("restart while busy"); // R8
  AST_SOFT_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !busy) else $error("busy under soft reset"); // R9
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_rd && (bit_idx >= IDX_W'(TA_POS))) |-> !mdio_oe) else $error("line not released"); // R4
  AST_STEP_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && (bit_idx != $past(bit_idx))) |-> $past(fall_tick)) else $error("step off fall"); // R11
endmodule

// File: rtl/mdio_master_ctl.sv
module mdio_master_ctl
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  parameter int SEL_W   = 3,
  parameter int RST_BIT = 31,
  parameter int PHY_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int HALF_W = 5;
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ADDR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_BUSY = ADDR_W'(5);

  logic [SEL_W-1:0] cfg_sel;
  logic             cfg_rst;
  logic             cmd_rd;
  logic [15:0]      addr_q;
  logic [15:0]      ctrl_q;

  logic              busy, done, rise_tick, fall_tick, mdc_run;
  logic              wr_cmd, wr_ctrl;
  logic [HALF_W-1:0] half_q;
  logic [15:0]       rd_data;

  assign wr_cmd  = reg_we && (reg_addr == A_CMD);
  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign mdc_run = busy && !cfg_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_sel <= '0;
      cfg_rst <= 1'b0;
      cmd_rd  <= 1'b0;
      addr_q  <= '0;
      ctrl_q  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CFG: begin
          cfg_sel <= reg_wdata[SEL_W-1:0];
          cfg_rst <= reg_wdata[RST_BIT];
        end
        A_CMD:  if (!busy) cmd_rd <= reg_wdata[0];
        A_ADDR: addr_q <= reg_wdata[15:0];
        A_CTRL: if (!busy && !cfg_rst) ctrl_q <= reg_wdata[15:0];
        default: ;
      endcase
    end
  end

  mdio_frame_engine #(.HALF_W(HALF_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (cfg_rst),
    .start_rd  (wr_cmd && reg_wdata[0]),
    .start_wr  (wr_ctrl),
    .phy       (addr_q[PHY_LSB +: 5]),
    .regn      (addr_q[4:0]),
    .wdata     (reg_wdata[15:0]),
    .half_in   (mdc_half(cfg_sel)),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .busy      (busy),
    .half_q    (half_q),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rd_data   (rd_data),
    .done      (done)
  );

  mdio_mdc_gen #(.HALF_W(HALF_W)) u_mdc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (mdc_run),
    .half      (half_q),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CFG: begin
        reg_rdata[SEL_W-1:0] = cfg_sel;
        reg_rdata[RST_BIT]   = cfg_rst;
      end
      A_CMD:   reg_rdata[0]    = cmd_rd;
      A_ADDR:  reg_rdata[15:0] = addr_q;
      A_CTRL:  reg_rdata[15:0] = ctrl_q;
      A_STAT:  reg_rdata[15:0] = rd_data;
      A_BUSY:  reg_rdata[0]    = busy;
      default: reg_rdata = '0;
    endcase
  end

  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc) else $error("mdc high while idle"); // R2
  AST_MDIO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mdc) && mdc) |-> ($stable(mdio_o) && $stable(mdio_oe))) else $error("mdio moved in high phase"); // R11
  AST_LAUNCH_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && ((reg_addr == A_CMD && reg_wdata[0]) || reg_addr == A_CTRL)))
    else $error("launch without request"); // R5
  AST_RESET_HOLDS_MDC: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rst |=> !mdc) else $error("mdc under soft reset"); // R9
endmodule

// File: tb/mdio_master_ctl_tb.sv
module mdio_master_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        phy_drv = 1'b1;

  always #10 clk = ~clk;

  mdio_master_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(phy_drv)
  );

  typedef struct {
    bit        rd;
    bit [4:0]  phy;
    bit [4:0]  rg;
    bit [15:0] data;
    int        half;
  } xact_t;

  xact_t q[$];
  int checks = 0, errors = 0, frames_seen = 0, cur_half = 2;
  int ratio_tbl[8] = '{4, 4, 6, 8, 10, 14, 20, 28};
  bit finished = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit [63:0] exp_frame(xact_t x);
    bit [63:0] f;
    f[63:32] = '1;
    f[31:30] = 2'b01;
    f[29:28] = x.rd ? 2'b10 : 2'b01;
    f[27:23] = x.phy;
    f[22:18] = x.rg;
    f[17:16] = x.rd ? 2'b00 : 2'b10;
    f[15:0]  = x.data;
    return f;
  endfunction

  // monitor + PHY model
  logic      pm = 1'b0, last_o = 1'b0;
  int        nbit = 0, run_len = 0;
  bit [63:0] got_o, got_oe;
  bit        half_bad = 0, hold_bad = 0;

  task automatic finish_frame();
    xact_t x;
    bit [63:0] e;
    frames_seen++;
    if (q.size() == 0) begin
      check(0, "R8", "unexpected frame", 1, 0);
    end else begin
      x = q.pop_front();
      e = exp_frame(x);
      if (!x.rd) begin
        check(got_o == e, "R3", "write frame bits", got_o, e);
        check(got_oe == '1, "R3", "write enable", got_oe, 64'hFFFF_FFFF_FFFF_FFFF);
      end else begin
        check(got_o[63:18] == e[63:18], "R4", "read header bits", got_o[63:18], e[63:18]);
        check(got_oe == {46'h3FFF_FFFF_FFFF, 18'h0}, "R4", "read enable", got_oe, {46'h3FFF_FFFF_FFFF, 18'h0});
      end
      check(!half_bad, "R1", "mdc level length", 0, x.half);
      check(!hold_bad, "R11", "mdio change in high phase", 1, 0);
    end
    nbit = 0; half_bad = 0; hold_bad = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mdc != pm) begin
        if (!(mdc && nbit == 0) && q.size() > 0 && run_len != q[0].half) half_bad = 1;
        run_len = 1;
      end else begin
        run_len++;
      end
      if (mdc && pm && (mdio_o !== last_o)) hold_bad = 1;
      if (mdc && !pm) begin
        got_o[63-nbit]  = mdio_o;
        got_oe[63-nbit] = mdio_oe;
        nbit++;
        if (nbit == 64) finish_frame();
      end
      if (!mdc && pm) begin
        if (q.size() > 0 && q[0].rd && nbit >= 48 && nbit < 64) phy_drv = q[0].data[63-nbit];
        else phy_drv = 1'b1;
      end
      if (!mdc && run_len > 40) begin
        nbit = 0; half_bad = 0; hold_bad = 0;
      end
      last_o = mdio_o;
      pm = mdc;
    end
  end

  // driver tasks
  task automatic wr(input int a, input bit [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output bit [31:0] d);
    @(negedge clk);
    reg_addr = 3'(a);
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    bit [31:0] b;
    for (int i = 0; i < 6000; i++) begin
      rd(5, b);
      if (b == 0) break;
    end
  endtask

  task automatic set_div(input int idx);
    wr(0, 32'(idx));
    cur_half = ratio_tbl[idx] / 2;
  endtask

  task automatic do_write(input bit [7:0] phy, input bit [7:0] rg, input bit [15:0] d);
    xact_t x;
    x.rd = 0; x.phy = phy[4:0]; x.rg = rg[4:0]; x.data = d; x.half = cur_half;
    q.push_back(x);
    wr(2, {16'h0, phy, rg});
    wr(3, {16'h0, d});
    wait_idle();
  endtask

  task automatic do_read(input bit [7:0] phy, input bit [7:0] rg, input bit [15:0] d);
    xact_t x;
    bit [31:0] s;
    x.rd = 1; x.phy = phy[4:0]; x.rg = rg[4:0]; x.data = d; x.half = cur_half;
    q.push_back(x);
    wr(1, 0);
    wr(2, {16'h0, phy, rg});
    wr(1, 1);
    wait_idle();
    rd(4, s);
    check(s[15:0] == d, "R4", "status read data", s[15:0], d);
    wr(1, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [31:0] v;
    int fs;
    xact_t x;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(5, v);
    check(v == 0, "R7", "busy after reset", v, 0);
    check(mdc == 0 && mdio_oe == 0, "R2", "mdc/oe after reset", {mdc, mdio_oe}, 0);

    set_div(0); do_write(8'h01, 8'h02, 16'hA5A5);          // R6 R3
    set_div(3); do_read(8'h03, 8'h04, 16'hBEEF);           // R4
    set_div(7); do_write(8'h1F, 8'h00, 16'h8001);          // R1
    set_div(5); do_read(8'h1F, 8'h1F, 16'h0001);           // R1 R4
    set_div(2); do_write(8'hE5, 8'h3A, 16'h1234);          // R10 truncation

    // R7 busy during frame
    set_div(1);
    x.rd = 0; x.phy = 5'h02; x.rg = 5'h03; x.data = 16'h0F0F; x.half = cur_half;
    q.push_back(x);
    wr(2, 32'h0000_0203);
    wr(3, 32'h0000_0F0F);
    rd(5, v);
    check(v == 1, "R7", "busy during frame", v, 1);
    // R8 launches while busy are dropped
    fs = frames_seen;
    wr(3, 32'h0000_7777);
    wr(1, 1);
    wait_idle();
    check(frames_seen == fs + 1, "R8", "frame count", frames_seen - fs, 1);
    rd(3, v);
    check(v[15:0] == 16'h0F0F, "R8", "ctrl kept", v[15:0], 16'h0F0F);
    rd(1, v);
    check(v[0] == 0, "R8", "cmd kept", v[0], 0);

    // R5 writing 0 to CMD starts nothing
    fs = frames_seen;
    wr(1, 0);
    repeat (60) @(negedge clk);
    rd(5, v);
    check(v == 0 && frames_seen == fs && mdc == 0, "R5", "cmd zero idle", v, 0);

    // R9 soft reset mid-frame
    wr(2, 32'h0000_0101);
    wr(3, 32'h0000_5555);
    repeat (30) @(negedge clk);
    wr(0, 32'h8000_0001);
    rd(5, v);
    check(v == 0, "R9", "busy under soft reset", v, 0);
    check(mdc == 0, "R9", "mdc under soft reset", mdc, 0);
    fs = frames_seen;
    wr(3, 32'h0000_AAAA);
    wr(1, 1);
    repeat (200) @(negedge clk);
    rd(5, v);
    check(v == 0 && mdc == 0 && frames_seen == fs, "R9", "no launch in soft reset", v, 0);
    wr(0, 32'h0000_0001);
    cur_half = 2;
    repeat (50) @(negedge clk);
    do_write(8'h04, 8'h05, 16'hC3C3);                      // recovery
    check(q.size() == 0, "R3", "scoreboard drained", q.size(), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule